// File: doc/BRIEF.md
# Multiplexed LED Common-Line Scanner

This block sequences the common lines of a time-multiplexed LED display. While it runs, a frame visits every common line whose enable bit is set, lowest index first. Each visit is a slot of a programmable number of prescaled ticks. The slot opens with a blanking interval, during which every common line is off, and then drives its own line for the rest of the slot. The index of the line being visited is an output, so a neighbouring block can select the matching segment data. A one-cycle interrupt marks the end of every frame. A longer blanking interval makes the display dimmer.

Software starts the scanner by writing a run bit. It asks the scanner to stop by writing the same bit to zero. The scanner then finishes the frame in progress before it clears its busy status, so software polls that status to learn when scanning has actually ended. The slot length can only be changed while the scanner is idle. The blanking length can be written at any time and takes effect at the next frame boundary.

Top module: `led_com_scanner`

## Requirements
- R1: After reset, `run_busy`, `frame_irq` and every bit of `com_out` are 0.
- R2: Within a frame, the lines whose bit in `com_mask` is 1 are visited in ascending index order. Lines whose bit is 0 are skipped. `com_mask` is sampled when each frame starts.
- R3: Each slot lasts `duty_wdata`+1 ticks, where a tick is a cycle with `tick` high. While `tick` is low, the outputs hold.
- R4: A slot is dark for its first `dead` ticks and lit for the rest. When the dead count is greater than the duty count, the slot stays dark throughout.
- R5: `com_out` is active high, with bit i driving line i. At most one bit is set, and when a bit is set, `com_idx` equals its index.
- R6: `frame_irq` is high for exactly one cycle after the edge that ends the last enabled slot of a frame.
- R7: A write of 1 to the run bit while idle sets `run_busy` at the next edge. The first frame starts on the edge after that.
- R8: A write of 0 to the run bit while busy lets the current frame complete. `run_busy` falls, and `com_out` goes dark, on the same edge that ends the frame.
- R9: If the scanner runs with `com_mask` all zero, it drives no line and raises no interrupt. A stop request then clears `run_busy` one edge after it is registered.
- R10: A duty write while `run_busy` is 1 is ignored. A duty write while idle is accepted.
- R11: A dead-count write is accepted at any time. It applies from the first frame that starts after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_wr | input | 1 | Write strobe for the run bit |
| en_wdata | input | 1 | Value written to the run bit |
| run_busy | output | 1 | 1 while the scanner runs; cleared by hardware after a stop |
| duty_wr | input | 1 | Write strobe for the duty count |
| duty_wdata | input | CNT_W | Slot length in ticks, minus one |
| dead_wr | input | 1 | Write strobe for the dead count |
| dead_wdata | input | CNT_W | Number of blank ticks at the start of each slot |
| com_mask | input | N_COM | Per-line enable, bit i for line i |
| tick | input | 1 | Prescaled timing strobe |
| com_out | output | N_COM | Active-high common line drives |
| com_idx | output | IDX_W | Index of the line being visited |
| frame_irq | output | 1 | One-cycle frame-end pulse |

## Verification
A corrupted line index or a bad priority pick appears at `com_out` within one slot, either as a line out of order or as a `com_idx` that does not match the lit bit. A slot counter that drifts shows up as a lit run of the wrong length in the same slot, and as a `frame_irq` that lands on the wrong cycle within one frame. A stop flag that is lost or set too early shows up at `run_busy` on the frame-end edge after the stop request. A dead count latched at the wrong moment changes the lit length in the frame where the change was expected, or in the frame before it.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;
   // width of an index able to address n lines (at least 1 bit)
   function automatic int unsigned idx_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/led_com_pick.sv
// Finds the lowest set mask bit whose index is >= from_idx.
module led_com_pick #(
   parameter int unsigned N_COM = 12,
   localparam int unsigned IDX_W = led_scan_pkg::idx_width(N_COM)
) (
   input  logic [N_COM-1:0] mask,
   input  logic [IDX_W:0]   from_idx,
   output logic             found,
   output logic [IDX_W-1:0] pick_idx
);
   logic [N_COM-1:0] qual;

   for (genvar i = 0; i < N_COM; i++) begin : g_qual
      assign qual[i] = mask[i] && ((IDX_W+1)'(i) >= from_idx);
   end

   always_comb begin
      found    = 1'b0;
      pick_idx = '0;
      for (int i = N_COM-1; i >= 0; i--) begin
         if (qual[i]) begin
            found    = 1'b1;
            pick_idx = IDX_W'(i);
         end
      end
   end

   always_comb begin
      if (found) a_pick_r2: assert (mask[pick_idx] && ({1'b0, pick_idx} >= from_idx));
   end
endmodule

// File: rtl/led_slot_timer.sv
// Counts ticks within one slot and flags blanking versus drive.
module led_slot_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] duty,
   input  logic [CNT_W-1:0] dead,
   output logic             slot_end,
   output logic             lit
);
   logic [CNT_W-1:0] cnt;

   assign slot_end = run && tick && (cnt == duty);
   assign lit      = run && (cnt >= dead);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (!run)    cnt <= '0;
      else if (tick)    cnt <= (cnt == duty) ? '0 : cnt + 1'b1;
   end

   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> cnt <= duty);
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(cnt));
endmodule

// File: rtl/led_com_scanner.sv
module led_com_scanner #(
   parameter int unsigned N_COM = 12,
   parameter int unsigned CNT_W = 8,
   localparam int unsigned IDX_W = led_scan_pkg::idx_width(N_COM)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_wr,
   input  logic             en_wdata,
   output logic             run_busy,
   input  logic             duty_wr,
   input  logic [CNT_W-1:0] duty_wdata,
   input  logic             dead_wr,
   input  logic [CNT_W-1:0] dead_wdata,
   input  logic [N_COM-1:0] com_mask,
   input  logic             tick,
   output logic [N_COM-1:0] com_out,
   output logic [IDX_W-1:0] com_idx,
   output logic             frame_irq
);
   if (N_COM < 1 || N_COM > 64) begin : g_bad_ncom
      $error("N_COM out of range");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cntw
      $error("CNT_W out of range");
   end

   logic             busy, stop_req, in_frame;
   logic [IDX_W-1:0] idx;
   logic [N_COM-1:0] mask_f;
   logic [CNT_W-1:0] duty_q, dead_pend, dead_act;
   logic             slot_end, lit;
   logic             start_found, next_found;
   logic [IDX_W-1:0] start_idx, next_idx;

   led_com_pick #(.N_COM(N_COM)) u_start (
      .mask(com_mask), .from_idx('0), .found(start_found), .pick_idx(start_idx));

   led_com_pick #(.N_COM(N_COM)) u_next (
      .mask(mask_f), .from_idx({1'b0, idx} + 1'b1),
      .found(next_found), .pick_idx(next_idx));

   led_slot_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(in_frame), .tick(tick),
      .duty(duty_q), .dead(dead_act), .slot_end(slot_end), .lit(lit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         stop_req  <= 1'b0;
         in_frame  <= 1'b0;
         idx       <= '0;
         mask_f    <= '0;
         duty_q    <= '0;
         dead_pend <= '0;
         dead_act  <= '0;
         frame_irq <= 1'b0;
      end else begin
         frame_irq <= 1'b0;
         if (en_wr) begin
            if (en_wdata) begin
               busy     <= 1'b1;
               stop_req <= 1'b0;
            end else if (busy) begin
               stop_req <= 1'b1;
            end
         end
         if (duty_wr && !busy) duty_q <= duty_wdata;
         if (dead_wr)          dead_pend <= dead_wdata;

         if (busy && !in_frame) begin
            if (stop_req) begin
               busy     <= 1'b0;
               stop_req <= 1'b0;
            end else if (start_found) begin
               in_frame <= 1'b1;
               idx      <= start_idx;
               mask_f   <= com_mask;
               dead_act <= dead_pend;
            end
         end else if (in_frame && slot_end) begin
            if (next_found) begin
               idx <= next_idx;
            end else begin
               frame_irq <= 1'b1;
               if (stop_req) begin
                  busy     <= 1'b0;
                  stop_req <= 1'b0;
                  in_frame <= 1'b0;
               end else if (start_found) begin
                  idx      <= start_idx;
                  mask_f   <= com_mask;
                  dead_act <= dead_pend;
               end else begin
                  in_frame <= 1'b0;
               end
            end
         end
      end
   end

   for (genvar i = 0; i < N_COM; i++) begin : g_drive
      assign com_out[i] = lit && (idx == IDX_W'(i));
   end

   assign com_idx  = idx;
   assign run_busy = busy;

   p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(com_out));
   p_idx_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|com_out) |-> com_out[com_idx]);
   p_dark_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (com_out == '0));
   p_stop_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(stop_req));
   p_duty_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(duty_q));
   p_lit_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|com_out) |-> mask_f[com_idx]);
endmodule

// File: tb/sim_led_com_scanner.sv
module sim_led_com_scanner;
   localparam int CLK_PERIOD = 10;
   localparam int N = 12;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         en_wr = 1'b0, en_wdata = 1'b0;
   logic         duty_wr = 1'b0, dead_wr = 1'b0;
   logic [W-1:0] duty_wdata = '0, dead_wdata = '0;
   logic [N-1:0] com_mask = '0;
   logic         tick = 1'b1;
   logic         run_busy, frame_irq;
   logic [N-1:0] com_out;
   logic [3:0]   com_idx;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   led_com_scanner #(.N_COM(N), .CNT_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
      .run_busy(run_busy), .duty_wr(duty_wr), .duty_wdata(duty_wdata),
      .dead_wr(dead_wr), .dead_wdata(dead_wdata), .com_mask(com_mask),
      .tick(tick), .com_out(com_out), .com_idx(com_idx), .frame_irq(frame_irq));

   task automatic check(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic int nth_set(input logic [N-1:0] m, input int s);
      int c = 0;
      for (int i = 0; i < N; i++) begin
         if (m[i]) begin
            if (c == s) return i;
            c++;
         end
      end
      return 0;
   endfunction

   // full run: start, optional dead/duty writes, stop request, compare every cycle
   task automatic run_stream(input logic [N-1:0] m, input int duty, input int dead0,
                             input int dead1, input int dead_k, input int dutyw_k,
                             input int stop_k);
      int n = $countones(m);
      int slot = duty + 1;
      int fr = n * slot;
      int kend = ((stop_k + 2 + fr - 1) / fr) * fr;
      @(negedge clk);
      com_mask = m; duty_wr = 1'b1; duty_wdata = W'(duty);
      dead_wr = 1'b1; dead_wdata = W'(dead0); tick = 1'b1;
      @(negedge clk);
      duty_wr = 1'b0; dead_wr = 1'b0; en_wr = 1'b1; en_wdata = 1'b1;
      @(negedge clk);
      en_wr = 1'b0;
      check("R7", "busy after start", run_busy, 1);
      check("R7", "dark before first frame", com_out, 0);
      for (int k = 0; k <= kend + 1; k++) begin
         int f, pos, dd, line;
         logic [N-1:0] exp_out;
         @(negedge clk);
         en_wr = 1'b0; dead_wr = 1'b0; duty_wr = 1'b0;
         f = k / fr;
         dd = (f * fr >= dead_k + 1) ? dead1 : dead0;
         pos = k % slot;
         line = nth_set(m, (k % fr) / slot);
         exp_out = (k < kend && pos >= dd) ? (N'(1) << line) : '0;
         check("R2/R3/R4", "com_out", com_out, exp_out);
         if (exp_out != 0) check("R5", "com_idx", com_idx, line);
         check("R8", "busy", run_busy, (k < kend) ? 1 : 0);
         check("R6", "frame_irq", frame_irq, (k > 0 && k % fr == 0 && k <= kend) ? 1 : 0);
         if (k == dead_k)  begin dead_wr = 1'b1; dead_wdata = W'(dead1); end
         if (k == dutyw_k) begin duty_wr = 1'b1; duty_wdata = W'(duty + 3); end
         if (k == stop_k)  begin en_wr = 1'b1; en_wdata = 1'b0; end
      end
   endtask

   task automatic t_reset();
      check("R1", "busy at reset", run_busy, 0);
      check("R1", "com_out at reset", com_out, 0);
      check("R1", "irq at reset", frame_irq, 0);
   endtask

   task automatic t_empty_mask();
      @(negedge clk);
      com_mask = '0; en_wr = 1'b1; en_wdata = 1'b1;
      @(negedge clk);
      en_wr = 1'b0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         check("R9", "busy with empty mask", run_busy, 1);
         check("R9", "no drive", com_out, 0);
         check("R9", "no irq", frame_irq, 0);
      end
      en_wr = 1'b1; en_wdata = 1'b0;
      @(negedge clk);
      en_wr = 1'b0;
      check("R9", "busy right after stop write", run_busy, 1);
      @(negedge clk);
      check("R9", "busy cleared", run_busy, 0);
   endtask

   task automatic t_tick_hold();
      @(negedge clk);
      com_mask = N'(12'h004); duty_wr = 1'b1; duty_wdata = 8'd2;
      dead_wr = 1'b1; dead_wdata = 8'd0; tick = 1'b0;
      @(negedge clk);
      duty_wr = 1'b0; dead_wr = 1'b0; en_wr = 1'b1; en_wdata = 1'b1;
      @(negedge clk);
      en_wr = 1'b0;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         check("R3", "held line without ticks", com_out, 12'h004);
         check("R3", "no irq without ticks", frame_irq, 0);
      end
      tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      check("R3", "irq after 1 tick", frame_irq, 0);
      tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      check("R3", "irq after 2 ticks", frame_irq, 0);
      tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      check("R6", "irq after 3 ticks", frame_irq, 1);
      @(negedge clk);
      check("R6", "irq single cycle", frame_irq, 0);
      en_wr = 1'b1; en_wdata = 1'b0; tick = 1'b1;
      @(negedge clk);
      en_wr = 1'b0;
      for (int k = 0; k < 8 && run_busy; k++) @(negedge clk);
      check("R8", "stopped after tick run", run_busy, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 3);
      t_reset();
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      // R2 R4: lines 0,5,6,7; 4-tick slots with 1 blank tick
      run_stream(N'(12'h0E1), 3, 1, 1, -1, -1, 20);
      // R10 R11: duty write ignored while running, dead change applies next frame
      run_stream(N'(12'h809), 2, 0, 2, 4, 5, 25);
      // R4: dead count beyond slot keeps lines dark
      run_stream(N'(12'h012), 1, 5, 5, -1, -1, 3);
      // all lines, one-tick slots; duty accepted while idle (R10)
      run_stream(N'(12'hFFF), 0, 0, 0, -1, -1, 30);
      t_empty_mask();
      t_tick_hold();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule